// File: doc/BRIEF.md
# Sixteen-bit Counter/Timer with Match, Capture and PWM

The block is a general-purpose timer peripheral. A timer counter advances once every (prescale + 1) count events, where a count event is either a cycle in which the peripheral count enable is high or a selected edge on the capture pin. Four match values are compared with the counter. Each one can flag an interrupt, restart the counter, halt it, and steer its own match output pin. In PWM mode a match output instead shows whether the counter has reached that channel's match value, giving a single-edge waveform whose period is set by another match channel programmed to restart the counter.

The capture pin is brought into the clock domain by a two-flop synchronizer and edge-detected. A selected edge copies the counter into a capture register and may raise an interrupt. Software talks to the block through a flat register port: a one-cycle write strobe, and a read path that is combinational from the address.

Top module: `tmr16`

## Requirements
- R1: After reset every register reads 0, all match outputs are low, and `irq` is low.
- R2: The prescale counter (address 3) counts count events from 0 up to the prescale limit (address 2). The event that finds it at the limit returns it to 0 and advances the timer counter (address 1) by one.
- R3: Control register (address 0): bit 0 is run and bit 1 is hold. With run clear, no count event changes the counter. With hold set, the timer and prescale counters are forced to 0 from the next cycle on.
- R4: A timer tick taken while the counter equals match value i (addresses 8 to 11) is a match of channel i. Match-control register (address 4) bit 3i+1 makes that tick load 0 instead of counting up, and bit 3i sets interrupt flag i.
- R5: With match-control bit 3i+2 set, a match of channel i clears the run bit and leaves the counter at the match value.
- R6: Output register (address 7) bits 3:0 hold the match output levels. Bits 2i+5:2i+4 select the action taken on a match of channel i: 00 no change, 01 drive low, 10 drive high, 11 toggle.
- R7: Interrupt register (address 13): bits 3:0 are match flags and bit 4 is the capture flag. The flags are sticky, writing 1 to a bit clears it, and `irq` is high while any flag is set.
- R8: Capture control (address 5): bit 0 selects rising edges, bit 1 selects falling edges, and bit 2 enables the capture flag. A selected edge on `cap_in` copies the counter into the capture register (address 6). An unselected edge leaves that register unchanged.
- R9: When control bit 2 is set, count events are synchronized `cap_in` edges, with control bit 3 selecting rising edges and bit 4 selecting falling edges. When bit 2 is clear, count events are cycles with `tick_en` high.
- R10: When PWM-enable bit i (address 12) is set, match output i is high exactly while the counter is at or above match value i. A match value of 0 keeps the output high.
- R11: Configuration registers read back what was written, masked to their defined widths (match control 12 bits, output register 12 bits, PWM enable 4 bits, capture control 3 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable from the peripheral clock divider |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cap_in | input | 1 | Capture / external count pin |
| match_out | output | 4 | Match output pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit counter and prescaler widths. Small prescale limits and periods can then be stepped through one tick at a time, so wrap points, match-tick alignment and the PWM edge position can be predicted exactly. Pin-driven counting and capture are driven with pulses wide enough to pass the synchronizer, so the counts that result from single-edge and both-edge selection can be told apart.

// File: rtl/tmr16.sv
module tmr16 #(
  parameter int TW = 16,
  parameter int PW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        cap_in,
  output logic [3:0]  match_out,
  output logic        irq
);
  localparam int NCH = 4;
  localparam logic [3:0] A_CTRL = 4'd0, A_TC = 4'd1, A_PR = 4'd2, A_PC = 4'd3,
                         A_MCR = 4'd4, A_CCR = 4'd5, A_CR = 4'd6, A_EMR = 4'd7,
                         A_MR0 = 4'd8, A_PWM = 4'd12, A_IR = 4'd13;

  logic [4:0]    ctrl_q;
  logic [TW-1:0] tc_q, cr_q;
  logic [PW-1:0] pr_q, pc_q;
  logic [11:0]   mcr_q;
  logic [2:0]    ccr_q;
  logic [NCH-1:0] emr_q, pwm_q;
  logic [7:0]    ema_q;
  logic [TW-1:0] mr_q [NCH];
  logic [4:0]    ir_q;
  logic [2:0]    sy_q;

  logic rise, fall, pin_ev, src_ev, pre_ev, pc_wrap, tmr_tick, cap_ev, do_rst, do_stop;
  logic [NCH-1:0] match_ev, m_irq, m_rst, m_stop;

  assign rise     = sy_q[1] & ~sy_q[2];
  assign fall     = ~sy_q[1] & sy_q[2];
  assign pin_ev   = (ctrl_q[3] & rise) | (ctrl_q[4] & fall);
  assign src_ev   = ctrl_q[2] ? pin_ev : tick_en;
  assign pre_ev   = ctrl_q[0] & ~ctrl_q[1] & src_ev;
  assign pc_wrap  = pc_q >= pr_q;
  assign tmr_tick = pre_ev & pc_wrap;
  assign cap_ev   = (ccr_q[0] & rise) | (ccr_q[1] & fall);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign m_irq[i]     = mcr_q[3*i];
    assign m_rst[i]     = mcr_q[3*i+1];
    assign m_stop[i]    = mcr_q[3*i+2];
    assign match_ev[i]  = tmr_tick & (tc_q == mr_q[i]);
    assign match_out[i] = pwm_q[i] ? (tc_q >= mr_q[i]) : emr_q[i];
  end

  assign do_rst  = |(match_ev & m_rst);
  assign do_stop = |(match_ev & m_stop);
  assign irq     = |ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy_q <= '0;
    else        sy_q <= {sy_q[1:0], cap_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (ctrl_q[1]) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (pre_ev) begin
      pc_q <= pc_wrap ? '0 : pc_q + 1'b1;
      if (tmr_tick) begin
        if (do_rst)        tc_q <= '0;
        else if (!do_stop) tc_q <= tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pr_q   <= '0;
      mcr_q  <= '0;
      ccr_q  <= '0;
      ema_q  <= '0;
      pwm_q  <= '0;
      for (int i = 0; i < NCH; i++) mr_q[i] <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[4:0];
      else if (do_stop)                 ctrl_q[0] <= 1'b0;
      if (reg_wr && reg_addr == A_PR)   pr_q  <= reg_wdata[PW-1:0];
      if (reg_wr && reg_addr == A_MCR)  mcr_q <= reg_wdata[11:0];
      if (reg_wr && reg_addr == A_CCR)  ccr_q <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_EMR)  ema_q <= reg_wdata[11:4];
      if (reg_wr && reg_addr == A_PWM)  pwm_q <= reg_wdata[3:0];
      for (int i = 0; i < NCH; i++)
        if (reg_wr && reg_addr == A_MR0 + 4'(i)) mr_q[i] <= reg_wdata[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emr_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_wr && reg_addr == A_EMR) emr_q[i] <= reg_wdata[i];
        else if (match_ev[i]) begin
          case (ema_q[2*i +: 2])
            2'b01:   emr_q[i] <= 1'b0;
            2'b10:   emr_q[i] <= 1'b1;
            2'b11:   emr_q[i] <= ~emr_q[i];
            default: emr_q[i] <= emr_q[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= '0;
      ir_q <= '0;
    end else begin
      if (cap_ev) cr_q <= tc_q;
      ir_q <= (ir_q & ~((reg_wr && reg_addr == A_IR) ? reg_wdata[4:0] : 5'd0))
              | {cap_ev & ccr_q[2], match_ev & m_irq};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = 16'(ctrl_q);
      A_TC:    reg_rdata = 16'(tc_q);
      A_PR:    reg_rdata = 16'(pr_q);
      A_PC:    reg_rdata = 16'(pc_q);
      A_MCR:   reg_rdata = 16'(mcr_q);
      A_CCR:   reg_rdata = 16'(ccr_q);
      A_CR:    reg_rdata = 16'(cr_q);
      A_EMR:   reg_rdata = 16'({ema_q, emr_q});
      4'd8:    reg_rdata = 16'(mr_q[0]);
      4'd9:    reg_rdata = 16'(mr_q[1]);
      4'd10:   reg_rdata = 16'(mr_q[2]);
      4'd11:   reg_rdata = 16'(mr_q[3]);
      A_PWM:   reg_rdata = 16'(pwm_q);
      A_IR:    reg_rdata = 16'(ir_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          wr_ir,
  input logic          wr_ctrl,
  input logic [4:0]    ctrl,
  input logic [TW-1:0] tc,
  input logic [3:0]    match_ev,
  input logic [11:0]   mcr
);
  logic [3:0] stop_mask;
  assign stop_mask = {mcr[11], mcr[8], mcr[5], mcr[2]};

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ir) |=> irq);

  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> (tc == '0));

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[1]) |=> $stable(tc));

  a_r4_step_or_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != $past(tc)) |-> ((tc == $past(tc) + 1'b1) || (tc == '0)));

  a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(match_ev & stop_mask)) && !wr_ctrl) |=> !ctrl[0]);
endmodule

bind tmr16 tmr16_chk #(.TW(TW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .wr_ir    (reg_wr && reg_addr == 4'd13),
  .wr_ctrl  (reg_wr && reg_addr == 4'd0),
  .ctrl     (ctrl_q),
  .tc       (tc_q),
  .match_ev (match_ev),
  .mcr      (mcr_q)
);

// File: tb/tmr16_tb_top.sv
module tmr16_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, reg_wr = 1'b0, cap_in = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0] match_out;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16 dut_i (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
               .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
               .cap_in(cap_in), .match_out(match_out), .irq(irq));

  // {write, addr, data, expected read}; readback and cleanup for R11
  localparam logic [36:0] VEC [14] = '{
    {1'b1, 4'd2,  16'h00AB, 16'h0000}, {1'b0, 4'd2,  16'h0000, 16'h00AB},
    {1'b1, 4'd10, 16'hBEEF, 16'h0000}, {1'b0, 4'd10, 16'h0000, 16'hBEEF},
    {1'b1, 4'd4,  16'hFFFF, 16'h0000}, {1'b0, 4'd4,  16'h0000, 16'h0FFF},
    {1'b1, 4'd7,  16'hFFFF, 16'h0000}, {1'b0, 4'd7,  16'h0000, 16'h0FFF},
    {1'b1, 4'd12, 16'hFFFF, 16'h0000}, {1'b0, 4'd12, 16'h0000, 16'h000F},
    {1'b1, 4'd5,  16'hFFFF, 16'h0000}, {1'b0, 4'd5,  16'h0000, 16'h0007},
    {1'b1, 4'd4,  16'h0000, 16'h0000}, {1'b0, 4'd4,  16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pin_level(input logic v);
    @(negedge clk);
    cap_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic restart();
    wr(4'd0, 16'h0002);
    wr(4'd0, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl", 4'd0, 16'h0);
    rd_chk("R1 tc", 4'd1, 16'h0);
    rd_chk("R1 ir", 4'd13, 16'h0);
    chk("R1 match_out", 16'(match_out), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);

    // R11 register readback table
    foreach (VEC[k]) begin
      if (VEC[k][36]) wr(VEC[k][35:32], VEC[k][31:16]);
      else rd_chk("R11 readback", VEC[k][35:32], VEC[k][15:0]);
    end
    wr(4'd7, 16'h0); wr(4'd12, 16'h0); wr(4'd5, 16'h0);

    // R2 prescaler, limit 2
    wr(4'd2, 16'd2);
    restart();
    ticks(9);
    rd_chk("R2 tc after 9 events", 4'd1, 16'd3);
    rd_chk("R2 pc after 9 events", 4'd3, 16'd0);
    ticks(1);
    rd_chk("R2 pc after 10 events", 4'd3, 16'd1);
    wr(4'd2, 16'd0);

    // R3 run gating and hold
    wr(4'd0, 16'h0000);
    ticks(5);
    rd_chk("R3 no count with run clear", 4'd1, 16'd3);
    wr(4'd0, 16'h0003);
    @(negedge clk);
    rd_chk("R3 hold clears tc", 4'd1, 16'd0);
    rd_chk("R3 hold clears pc", 4'd3, 16'd0);

    // R4 period restart, R6 toggle, R7 flags
    wr(4'd8, 16'd5);
    wr(4'd4, 16'h0003);
    wr(4'd7, 16'h0030);
    restart();
    ticks(14);
    rd_chk("R4 tc wraps at match", 4'd1, 16'd2);
    chk("R6 toggled twice", 16'(match_out[0]), 16'd0);
    rd_chk("R4 flag ch0", 4'd13, 16'h0001);
    chk("R7 irq high", 16'(irq), 16'd1);
    ticks(4);
    rd_chk("R4 tc restarted", 4'd1, 16'd0);
    chk("R6 toggled three times", 16'(match_out[0]), 16'd1);
    wr(4'd13, 16'h001F);
    rd_chk("R7 write-one clears", 4'd13, 16'h0);
    chk("R7 irq low", 16'(irq), 16'd0);

    // R5 stop on match
    wr(4'd0, 16'h0002);
    wr(4'd4, 16'h0020);
    wr(4'd9, 16'd3);
    wr(4'd7, 16'h0000);
    wr(4'd0, 16'h0001);
    ticks(10);
    rd_chk("R5 tc held at match", 4'd1, 16'd3);
    rd_chk("R5 run cleared", 4'd0, 16'h0000);

    // R6 force low, force high, no change on channel 2
    wr(4'd0, 16'h0002);
    wr(4'd4, 16'h0400);
    wr(4'd11, 16'd9);
    wr(4'd10, 16'd2);
    wr(4'd7, 16'h0104);
    wr(4'd0, 16'h0001);
    ticks(3);
    chk("R6 force low", 16'(match_out[2]), 16'd0);
    wr(4'd7, 16'h0200);
    ticks(10);
    chk("R6 force high", 16'(match_out[2]), 16'd1);
    wr(4'd7, 16'h0004);
    ticks(10);
    chk("R6 no change keeps level", 16'(match_out[2]), 16'd1);

    // R10 PWM, period on channel 3
    wr(4'd0, 16'h0002);
    wr(4'd8, 16'd4);
    wr(4'd9, 16'd0);
    wr(4'd7, 16'h0000);
    wr(4'd12, 16'h0003);
    wr(4'd0, 16'h0001);
    ticks(3);
    chk("R10 below match low, zero match high", 16'(match_out), 16'h0002);
    ticks(1);
    chk("R10 at match high", 16'(match_out), 16'h0003);
    ticks(6);
    chk("R10 low after period restart", 16'(match_out), 16'h0002);
    wr(4'd12, 16'h0000);

    // R9 capture pin as count source
    wr(4'd0, 16'h0002);
    wr(4'd4, 16'h0000);
    wr(4'd0, 16'h000D);
    for (int p = 0; p < 3; p++) begin pin_level(1'b1); pin_level(1'b0); end
    rd_chk("R9 rising edges counted", 4'd1, 16'd3);
    wr(4'd0, 16'h001D);
    for (int p = 0; p < 2; p++) begin pin_level(1'b1); pin_level(1'b0); end
    rd_chk("R9 both edges counted", 4'd1, 16'd7);
    ticks(4);
    rd_chk("R9 tick_en ignored on pin source", 4'd1, 16'd7);

    // R8 capture
    restart();
    wr(4'd5, 16'h0005);
    ticks(7);
    pin_level(1'b1);
    pin_level(1'b0);
    rd_chk("R8 rising capture", 4'd6, 16'd7);
    rd_chk("R8 capture flag", 4'd13, 16'h0010);
    chk("R8 irq", 16'(irq), 16'd1);
    wr(4'd13, 16'h0010);
    wr(4'd5, 16'h0002);
    ticks(3);
    pin_level(1'b1);
    rd_chk("R8 rising ignored", 4'd6, 16'd7);
    pin_level(1'b0);
    rd_chk("R8 falling capture", 4'd6, 16'd10);
    rd_chk("R8 no flag without enable", 4'd13, 16'h0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule